// File: doc/BRIEF.md
# Bit-Serial DRAM Delay Line Controller

This block uses an external dynamic RAM with multiplexed addressing as a very long one-bit shift register. It is meant for a bit-serial audio encoder and decoder pair. Every sample period is one access cycle of fixed length at the current address. In that cycle the bit stored there is read out and the new input bit is written in its place. The address counter then steps to the next location. After a full sweep of the counter, a written bit comes back out, so the block is a delay line of fixed length.

The counter is split into a row half and a column half, and the two halves share one narrow address bus. The row half is the low part of the counter, so consecutive accesses walk through every row. This walk is the only refresh the memory gets. An elaboration check confirms that one full row sweep fits inside the memory's refresh window at the configured clock. A sample clock is exported so that the external converters can run in step with the accesses. Several memories can share the address bus and strobes to make the delay longer. Each extra memory stores the bit that the memory before it has just released.

Top module: `dram_serial_delay`

## Requirements
- R1: `bit_o` equals the `bit_i` value written `LANES * 2**ADDR_W` accesses earlier. Before that many accesses have run, it shows the initial memory contents.
- R2: Every access lasts 9 clocks, phases 0 to 8, with phase 0 the first cycle after reset. `smp_clk_o` is high in phases 0 to 4 and low in phases 5 to 8, so it rises once per access.
- R3: The strobes are active low. `dram_ras_n_o` is low in phases 1 to 7, `dram_cas_n_o` in phases 3 to 6 and `dram_we_n_o` in phases 5 and 6. CAS falls only while RAS is already low, and RAS rises only after CAS and write have risen.
- R4: `dram_addr_o` carries the low `ADDR_W/2` counter bits (the row) in phases 0 and 1, and the high half (the column) in phases 2 to 8. The counter advances by one at the end of phase 8.
- R5: After all ones, the counter wraps to zero.
- R6: `bit_o` changes only at the end of phase 8. It then holds that value for the whole next access.
- R7: `bit_i` is sampled only at the end of phase 4 and is driven on `dram_d_o[0]` during the write. A change to `bit_i` in phases 5 to 8 has no effect on the stored bit.
- R8: While synchronous reset is high, the block holds the following state: counter at zero, phase 0, all strobes high, `smp_clk_o` high, address bus zero and `bit_o` zero. An access begun before reset is abandoned.
- R9: In lane k > 0, `dram_d_o[k]` carries the bit that lane k-1 read in the same access. Lane 0 carries the input bit.
- R10: A complete row sweep takes `2**(ADDR_W/2) * 9` clocks. The configuration is rejected at elaboration if this exceeds the refresh window given by `REFRESH_US` at `CLK_HZ`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial bit to store |
| bit_o | output | 1 | Delayed serial bit |
| smp_clk_o | output | 1 | Sample clock, one period per access |
| dram_addr_o | output | ADDR_W/2 | Multiplexed row/column address |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_d_o | output | LANES | Write data, one bit per memory |
| dram_q_i | input | LANES | Read data, one bit per memory |

## Verification
A bit cannot be seen at the output until the counter has swept every address in every chained memory. The stimulus is therefore a long run of accesses with a small counter width and two lanes. Distinct patterns fill the memory, and the later patterns expose the earlier ones. During each access the bench changes the input bit after its sampling point, so that a late capture shows up as a wrong bit a full delay later. A reset is also applied in the middle of an access to show that the access is abandoned.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  localparam int ACCESS_CLKS = 9;

  typedef enum logic [3:0] {
    PH_ROW   = 4'd0,
    PH_RAS   = 4'd1,
    PH_COL   = 4'd2,
    PH_CAS   = 4'd3,
    PH_READ  = 4'd4,
    PH_WR0   = 4'd5,
    PH_WR1   = 4'd6,
    PH_CASUP = 4'd7,
    PH_RASUP = 4'd8
  } phase_e;

  function automatic phase_e phase_after(phase_e p);
    if (p == PH_RASUP) return PH_ROW;
    return phase_e'(4'(p) + 4'd1);
  endfunction

  function automatic logic ras_active(phase_e p);
    return (p != PH_ROW) && (p != PH_RASUP);
  endfunction

  function automatic logic cas_active(phase_e p);
    return (p == PH_CAS) || (p == PH_READ) || (p == PH_WR0) || (p == PH_WR1);
  endfunction

  function automatic logic we_active(phase_e p);
    return (p == PH_WR0) || (p == PH_WR1);
  endfunction

  function automatic logic smp_high(phase_e p);
    return 4'(p) <= 4'(PH_READ);
  endfunction

  function automatic logic row_on_bus(phase_e p);
    return (p == PH_ROW) || (p == PH_RAS);
  endfunction

endpackage

// File: rtl/dsd_phase_seq.sv
module dsd_phase_seq
  import dsd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic row_next_o,
  output logic capture_o,
  output logic commit_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic smp_o
);

  phase_e phase_q;
  phase_e phase_nxt;

  assign phase_nxt  = phase_after(phase_q);
  assign row_next_o = row_on_bus(phase_nxt);
  assign capture_o  = (phase_q == PH_READ);
  assign commit_o   = (phase_q == PH_RASUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_ROW;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      smp_o   <= 1'b1;
    end else begin
      phase_q <= phase_nxt;
      ras_n_o <= !ras_active(phase_nxt);
      cas_n_o <= !cas_active(phase_nxt);
      we_n_o  <= !we_active(phase_nxt);
      smp_o   <= smp_high(phase_nxt);
    end
  end

  // R3
  cas_after_ras_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n_o) |-> (!ras_n_o && $stable(ras_n_o)));

  // R3
  we_inside_cas_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n_o |-> (!cas_n_o && !ras_n_o));

  // R3
  ras_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n_o) |-> (cas_n_o && we_n_o));

  // R2
  smp_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(smp_o) |-> $fell(we_n_o));

endmodule

// File: rtl/dsd_addr_ctr.sv
module dsd_addr_ctr #(
  parameter int ADDR_W = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     advance_i,
  input  logic                     row_next_i,
  output logic [ADDR_W/2-1:0]      addr_o
);

  localparam int BUS_W = ADDR_W / 2;

  logic [ADDR_W-1:0] ctr_q;
  logic [ADDR_W-1:0] ctr_nxt;

  function automatic logic [BUS_W-1:0] row_part(logic [ADDR_W-1:0] c);
    return c[BUS_W-1:0];
  endfunction

  function automatic logic [BUS_W-1:0] col_part(logic [ADDR_W-1:0] c);
    return c[ADDR_W-1:BUS_W];
  endfunction

  assign ctr_nxt = advance_i ? ctr_q + 1'b1 : ctr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q  <= '0;
      addr_o <= '0;
    end else begin
      ctr_q  <= ctr_nxt;
      addr_o <= row_next_i ? row_part(ctr_nxt) : col_part(ctr_nxt);
    end
  end

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    !advance_i |=> $stable(ctr_q));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (advance_i && (&ctr_q)) |=> (ctr_q == '0));

endmodule

// File: rtl/dsd_lane_path.sv
module dsd_lane_path #(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic             commit_i,
  input  logic             bit_i,
  input  logic [LANES-1:0] dram_q_i,
  output logic [LANES-1:0] dram_d_o,
  output logic             bit_o
);

  logic [LANES-1:0] rd_lat_q;
  logic             in_lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_lat_q <= '0;
      in_lat_q <= 1'b0;
      bit_o    <= 1'b0;
    end else begin
      if (capture_i) begin
        rd_lat_q <= dram_q_i;
        in_lat_q <= bit_i;
      end
      if (commit_i) bit_o <= rd_lat_q[LANES-1];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_head
      assign dram_d_o[g] = in_lat_q;
    end else begin : g_chain
      assign dram_d_o[g] = rd_lat_q[g-1];
    end
  end

  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(bit_o));

  // R7
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture_i |=> $stable(dram_d_o));

endmodule

// File: rtl/dram_serial_delay.sv
module dram_serial_delay
  import dsd_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int LANES      = 1,
  parameter int CLK_HZ     = 12_000_000,
  parameter int REFRESH_US = 8000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_i,
  output logic                  bit_o,
  output logic                  smp_clk_o,
  output logic [ADDR_W/2-1:0]   dram_addr_o,
  output logic                  dram_ras_n_o,
  output logic                  dram_cas_n_o,
  output logic                  dram_we_n_o,
  output logic [LANES-1:0]      dram_d_o,
  input  logic [LANES-1:0]      dram_q_i
);

  localparam int    BUS_W       = ADDR_W / 2;
  localparam longint SWEEP_CLKS  = (longint'(1) << BUS_W) * ACCESS_CLKS;
  localparam longint WINDOW_CLKS = (longint'(CLK_HZ) * REFRESH_US) / 1_000_000;

  // R10
  initial begin
    refresh_window_chk: assert (SWEEP_CLKS <= WINDOW_CLKS)
      else $error("row sweep of %0d clocks exceeds refresh window of %0d", SWEEP_CLKS, WINDOW_CLKS);
    even_width_chk: assert ((ADDR_W % 2) == 0 && LANES >= 1)
      else $error("counter width must be even and LANES at least one");
  end

  logic row_next;
  logic capture;
  logic commit;

  dsd_phase_seq i_seq (
    .clk        (clk),
    .rst        (rst),
    .row_next_o (row_next),
    .capture_o  (capture),
    .commit_o   (commit),
    .ras_n_o    (dram_ras_n_o),
    .cas_n_o    (dram_cas_n_o),
    .we_n_o     (dram_we_n_o),
    .smp_o      (smp_clk_o)
  );

  dsd_addr_ctr #(.ADDR_W(ADDR_W)) i_addr (
    .clk        (clk),
    .rst        (rst),
    .advance_i  (commit),
    .row_next_i (row_next),
    .addr_o     (dram_addr_o)
  );

  dsd_lane_path #(.LANES(LANES)) i_lane (
    .clk       (clk),
    .rst       (rst),
    .capture_i (capture),
    .commit_i  (commit),
    .bit_i     (bit_i),
    .dram_q_i  (dram_q_i),
    .dram_d_o  (dram_d_o),
    .bit_o     (bit_o)
  );

endmodule

// File: tb/test_dram_serial_delay.sv
module test_dram_serial_delay;

  localparam int AW    = 6;
  localparam int LN    = 2;
  localparam int BW    = AW / 2;
  localparam int DEPTH = 1 << AW;
  localparam int DLY   = LN * DEPTH;
  localparam int NPAT  = 5;
  localparam logic [63:0] PAT [NPAT] = '{
    64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'hAAAA_5555_F0F0_0FF0,
    64'h1234_5678_9ABC_DEF1,
    64'hC3A5_0000_FFFF_7E81
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic dout, smp, ras_n, cas_n, we_n;
  logic [BW-1:0] addr;
  logic [LN-1:0] dd, dq;

  int checks = 0;
  int errors = 0;
  int n = 0;
  int cyc = 0;
  int last_row0 = -1;
  int row_gap = 0;
  logic hist [NPAT*64];

  always #10 clk = ~clk;

  dram_serial_delay #(.ADDR_W(AW), .LANES(LN), .CLK_HZ(50_000_000), .REFRESH_US(8000)) i_dram_serial_delay (
    .clk(clk), .rst(rst), .bit_i(din), .bit_o(dout), .smp_clk_o(smp),
    .dram_addr_o(addr), .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n), .dram_we_n_o(we_n),
    .dram_d_o(dd), .dram_q_i(dq)
  );

  // behavioural memory, one array per lane
  logic mem [LN][DEPTH];
  logic [BW-1:0] row_l = '0, col_l = '0;
  logic ras_p = 1'b1, cas_p = 1'b1;
  initial begin
    dq = '0;
    for (int l = 0; l < LN; l++) for (int a = 0; a < DEPTH; a++) mem[l][a] = 1'b0;
  end
  always @(negedge clk) begin
    cyc++;
    if (!ras_n && ras_p) begin
      row_l = addr;
      if (addr == '0) begin
        if (last_row0 >= 0) row_gap = cyc - last_row0;
        last_row0 = cyc;
      end
    end
    if (!cas_n && cas_p) col_l = addr;
    if (!cas_n) begin
      for (int l = 0; l < LN; l++) dq[l] = mem[l][{col_l, row_l}];
      if (!we_n) for (int l = 0; l < LN; l++) mem[l][{col_l, row_l}] = dd[l];
    end
    ras_p = ras_n;
    cas_p = cas_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (access %0d)", req, act, exp, n);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run_access(input logic b);
    logic exp_out, exp_l1;
    int a;
    exp_out = (n - 1 >= DLY) ? hist[n-1-DLY] : 1'b0;
    exp_l1  = (n >= DEPTH) ? hist[n-DEPTH] : 1'b0;
    a = n % DEPTH;
    chk("R1 delayed bit", 32'(dout), 32'(exp_out));
    din = b;
    hist[n] = b;
    for (int p = 0; p < 9; p++) begin
      chk("R3 ras", 32'(ras_n), 32'(!(p >= 1 && p <= 7)));
      chk("R3 cas", 32'(cas_n), 32'(!(p >= 3 && p <= 6)));
      chk("R3 we", 32'(we_n), 32'(!(p == 5 || p == 6)));
      chk("R2 sample clock", 32'(smp), 32'(p <= 4));
      if (p <= 1) chk((a == 0 && n > 0) ? "R5 row after wrap" : "R4 row", 32'(addr), 32'(a % (1 << BW)));
      else        chk((a == 0 && n > 0) ? "R5 col after wrap" : "R4 col", 32'(addr), 32'(a >> BW));
      if (p == 5) begin
        chk("R7 write data lane0", 32'(dd[0]), 32'(b));
        chk("R9 write data lane1", 32'(dd[1]), 32'(exp_l1));
      end
      if (p == 6) din = ~b;  // R7: late change must be ignored
      if (p == 8) chk("R6 output held", 32'(dout), 32'(exp_out));
      @(negedge clk);
    end
    n++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8 ras idle", 32'(ras_n), 32'(1));
    chk("R8 cas idle", 32'(cas_n), 32'(1));
    chk("R8 we idle", 32'(we_n), 32'(1));
    chk("R8 smp idle", 32'(smp), 32'(1));
    chk("R8 addr zero", 32'(addr), 32'(0));
    chk("R8 output zero", 32'(dout), 32'(0));
    rst = 1'b0;

    for (int pi = 0; pi < NPAT; pi++)
      for (int bi = 0; bi < 64; bi++)
        run_access(PAT[pi][bi]);

    // R10 row sweep period
    chk("R10 row sweep clocks", 32'(row_gap), 32'((1 << BW) * 9));
    checks++;
    if (row_gap > 400000) begin errors++; $display("FAIL R10 sweep %0d over window", row_gap); end

    // R8 reset in the middle of an access
    repeat (3) @(negedge clk);
    chk("R8 mid-access ras active", 32'(ras_n), 32'(0));
    rst = 1'b1;
    @(negedge clk);
    chk("R8 abandon ras", 32'(ras_n), 32'(1));
    chk("R8 abandon cas", 32'(cas_n), 32'(1));
    chk("R8 abandon addr", 32'(addr), 32'(0));
    chk("R8 abandon output", 32'(dout), 32'(0));
    rst = 1'b0;
    @(negedge clk);
    chk("R8 restart ras", 32'(ras_n), 32'(0));
    chk("R8 restart row zero", 32'(addr), 32'(0));
    finish_run();
  end

endmodule